// File: doc/BRIEF.md
# Tile Pixel Fetcher with Colour Lookup

This block turns one 16-bit tile name into the 64 coloured pixels of an 8x8 tile. The name selects a 32-byte pattern in video memory and one of four 16-colour palettes. The block reads the pattern one byte at a time through a synchronous read port that has one cycle of latency. Each byte holds two 4-bit colour indices, and the block sends them out in raster order. Each index is looked up in a built-in 64-entry colour store of 12-bit packed colour words. The result leaves as a 24-bit RGB value on a valid/ready stream. A one-cycle done strobe follows the last pixel.

The same colour store also drives a separate, purely combinational background-colour output. That output is selected by a background control byte. The colour store is loaded through a simple write port.

Top module: `tile_pixel_fetcher`

## Requirements
- R1: After reset, `req_ready` is 1, and `pix_valid` and `done` are 0.
- R2: For a name N, the k-th pattern byte read (k = 0..31) uses `vram_addr` = {N[10:0], 5'b0} + k. The read is marked by `vram_re`. `vram_rdata` carries that byte one cycle after the address.
- R3: Each pattern byte yields two pixels: bits 7:4 first, then bits 3:0. The next byte follows only after both.
- R4: The colour store entry used for a pixel is palette*16 + index. The palette is N[14:13] and the index is the pixel's 4-bit value.
- R5: A 12-bit colour word c expands to `pix_rgb` = {c[3:0],4'h0, c[7:4],4'h0, c[11:8],4'h0}. Bits 3:0, 11:8 and 19:16 are always zero.
- R6: Each accepted request produces exactly 64 pixel handshakes. `done` is then high for exactly one cycle, in the cycle after the last handshake. `req_ready` is 0 from acceptance until that cycle.
- R7: While `pix_valid` is 1 and `pix_ready` is 0, `pix_valid` stays 1 and `pix_rgb` does not change, unless the colour store is written. No pixel is lost or repeated.
- R8: `bg_rgb` is the R5 expansion of colour store entry {bg_ctl[5:4], bg_ctl[3:0]}. Bits 7:6 of `bg_ctl` have no effect.
- R9: A write with `cram_we` = 1 stores `cram_wdata` at `cram_waddr`. The new value is visible on the outputs from the next cycle.
- R10: Name bits 15, 12 and 11 do not affect addresses or colours.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Tile request present |
| req_ready | output | 1 | Block idle, request accepted |
| req_name | input | 16 | Tile name entry |
| vram_re | output | 1 | Pattern read strobe |
| vram_addr | output | 16 | Pattern byte address |
| vram_rdata | input | 8 | Pattern byte, one cycle after address |
| cram_we | input | 1 | Colour store write enable |
| cram_waddr | input | 6 | Colour store write index |
| cram_wdata | input | 12 | Packed colour word |
| pix_valid | output | 1 | Pixel available |
| pix_ready | input | 1 | Consumer accepts pixel |
| pix_rgb | output | 24 | Expanded pixel colour |
| done | output | 1 | One-cycle end-of-tile strobe |
| bg_ctl | input | 8 | Background palette and index |
| bg_rgb | output | 24 | Expanded background colour |

## Verification
The bench uses random stall patterns on `pix_ready`. These would expose a design that advances its byte offset or nibble select without a handshake: it would skip or repeat pixels and shift every later comparison. Names with bit 15 and bits 12:11 set, and the top tile index 0x7FF, catch a design that takes the wrong name slice for the address or the palette. That design would read the wrong bytes or the wrong quarter of the colour store. Separate checks on each colour field catch swapped nibble order and a wrong byte layout. Checks of `done` one cycle after the 64th pixel, and silence after it, catch an off-by-one tile length. Background probes with random upper bits catch a selector that decodes too many bits.

// File: rtl/tpf_pkg.sv
package tpf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CAP,
        ST_HI,
        ST_LO
    } tpf_state_e;

    // Reference into the colour store: palette select and colour index.
    typedef struct packed {
        logic [1:0] pal;
        logic [3:0] idx;
    } tpf_cref_t;

    // Packed 3x4-bit colour word to 24-bit output, each field in the high
    // nibble of its own byte.
    function automatic logic [23:0] tpf_expand(input logic [11:0] cw);
        return {cw[3:0], 4'h0, cw[7:4], 4'h0, cw[11:8], 4'h0};
    endfunction

endpackage

// File: rtl/tpf_cram.sv
module tpf_cram #(
    parameter int ENTRIES = 64,
    parameter int CW      = 12,
    localparam int AW     = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [CW-1:0] wdata,
    input  logic [AW-1:0] ra_addr,
    output logic [CW-1:0] ra_data,
    input  logic [AW-1:0] rb_addr,
    output logic [CW-1:0] rb_data
);

    logic [CW-1:0] mem_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign ra_data = mem_q[ra_addr];
    assign rb_data = mem_q[rb_addr];

endmodule

// File: rtl/tpf_seq.sv
module tpf_seq
    import tpf_pkg::*;
#(
    parameter int VAW        = 16,
    parameter int TILE_BYTES = 32,
    parameter int PAL_LSB    = 13,
    localparam int OFS_W     = $clog2(TILE_BYTES),
    localparam int IDX_W     = VAW - OFS_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           req_valid,
    output logic           req_ready,
    input  logic [15:0]    req_name,
    output logic           vram_re,
    output logic [VAW-1:0] vram_addr,
    input  logic [7:0]     vram_rdata,
    output logic           pix_valid,
    input  logic           pix_ready,
    output tpf_cref_t      pix_ref,
    output logic           done
);

    localparam logic [OFS_W-1:0] LAST_OFS = OFS_W'(TILE_BYTES - 1);

    tpf_state_e       state_q;
    logic [IDX_W-1:0] tile_q;
    logic [1:0]       pal_q;
    logic [OFS_W-1:0] ofs_q;
    logic [7:0]       byte_q;
    logic             done_q;

    // Name bits that select neither the tile nor the palette.
    logic unused_name_bits;
    assign unused_name_bits = ^{req_name[15], req_name[PAL_LSB-1:IDX_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            tile_q  <= '0;
            pal_q   <= '0;
            ofs_q   <= '0;
            byte_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        tile_q  <= req_name[IDX_W-1:0];
                        pal_q   <= req_name[PAL_LSB+1:PAL_LSB];
                        ofs_q   <= '0;
                        state_q <= ST_ADDR;
                    end
                end
                ST_ADDR: state_q <= ST_CAP;
                ST_CAP: begin
                    byte_q  <= vram_rdata;
                    state_q <= ST_HI;
                end
                ST_HI: begin
                    if (pix_ready) state_q <= ST_LO;
                end
                ST_LO: begin
                    if (pix_ready) begin
                        if (ofs_q == LAST_OFS) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            ofs_q   <= ofs_q + 1'b1;
                            state_q <= ST_ADDR;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready   = (state_q == ST_IDLE);
    assign vram_re     = (state_q == ST_ADDR);
    assign vram_addr   = {tile_q, ofs_q};
    assign pix_valid   = (state_q == ST_HI) || (state_q == ST_LO);
    assign pix_ref.pal = pal_q;
    assign pix_ref.idx = (state_q == ST_HI) ? byte_q[7:4] : byte_q[3:0];
    assign done        = done_q;

endmodule

// File: rtl/tile_pixel_fetcher.sv
module tile_pixel_fetcher
    import tpf_pkg::*;
#(
    parameter int VAW        = 16,
    parameter int TILE_BYTES = 32,
    parameter int CRAM_N     = 64,
    parameter int CW         = 12,
    localparam int CAW       = $clog2(CRAM_N)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           req_valid,
    output logic           req_ready,
    input  logic [15:0]    req_name,
    output logic           vram_re,
    output logic [VAW-1:0] vram_addr,
    input  logic [7:0]     vram_rdata,
    input  logic           cram_we,
    input  logic [CAW-1:0] cram_waddr,
    input  logic [CW-1:0]  cram_wdata,
    output logic           pix_valid,
    input  logic           pix_ready,
    output logic [23:0]    pix_rgb,
    output logic           done,
    input  logic [7:0]     bg_ctl,
    output logic [23:0]    bg_rgb
);

    tpf_cref_t     pix_ref;
    tpf_cref_t     bg_ref;
    logic [CW-1:0] pix_word;
    logic [CW-1:0] bg_word;

    logic unused_bg_bits;
    assign unused_bg_bits = ^bg_ctl[7:6];

    assign bg_ref.pal = bg_ctl[5:4];
    assign bg_ref.idx = bg_ctl[3:0];

    tpf_seq #(
        .VAW        (VAW),
        .TILE_BYTES (TILE_BYTES)
    ) seq_i (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_name   (req_name),
        .vram_re    (vram_re),
        .vram_addr  (vram_addr),
        .vram_rdata (vram_rdata),
        .pix_valid  (pix_valid),
        .pix_ready  (pix_ready),
        .pix_ref    (pix_ref),
        .done       (done)
    );

    tpf_cram #(
        .ENTRIES (CRAM_N),
        .CW      (CW)
    ) cram_i (
        .clk     (clk),
        .we      (cram_we),
        .waddr   (cram_waddr),
        .wdata   (cram_wdata),
        .ra_addr (CAW'(pix_ref)),
        .ra_data (pix_word),
        .rb_addr (CAW'(bg_ref)),
        .rb_data (bg_word)
    );

    assign pix_rgb = tpf_expand(pix_word);
    assign bg_rgb  = tpf_expand(bg_word);

endmodule

// File: rtl/tile_pixel_fetcher_chk.sv
module tile_pixel_fetcher_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic [10:0] tile_idx,
    input logic        vram_re,
    input logic [15:0] vram_addr,
    input logic        cram_we,
    input logic        pix_valid,
    input logic        pix_ready,
    input logic [23:0] pix_rgb,
    input logic        done
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (!pix_valid && !done));

    assert_first_read_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=>
            (vram_re && vram_addr[4:0] == 5'd0 && vram_addr[15:5] == $past(tile_idx)));

    assert_zero_fields_R5: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> (pix_rgb[3:0] == 4'h0 && pix_rgb[11:8] == 4'h0 && pix_rgb[19:16] == 4'h0));

    assert_busy_not_ready_R6: assert property (@(posedge clk) disable iff (rst)
        (pix_valid || vram_re) |-> !req_ready);

    assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && !pix_ready && !cram_we) |=> (pix_valid && $stable(pix_rgb)));

endmodule

bind tile_pixel_fetcher tile_pixel_fetcher_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .tile_idx  (req_name[10:0]),
    .vram_re   (vram_re),
    .vram_addr (vram_addr),
    .cram_we   (cram_we),
    .pix_valid (pix_valid),
    .pix_ready (pix_ready),
    .pix_rgb   (pix_rgb),
    .done      (done)
);

// File: tb/tile_pixel_fetcher_tb_top.sv
module tile_pixel_fetcher_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_name = '0;
    logic        vram_re;
    logic [15:0] vram_addr;
    logic [7:0]  vram_rdata = '0;
    logic        cram_we = 1'b0;
    logic [5:0]  cram_waddr = '0;
    logic [11:0] cram_wdata = '0;
    logic        pix_valid;
    logic        pix_ready = 1'b0;
    logic [23:0] pix_rgb;
    logic        done;
    logic [7:0]  bg_ctl = '0;
    logic [23:0] bg_rgb;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;
    logic [11:0] cram_model [64];

    always #5 clk = ~clk;

    tile_pixel_fetcher dut_i (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_name   (req_name),
        .vram_re    (vram_re),
        .vram_addr  (vram_addr),
        .vram_rdata (vram_rdata),
        .cram_we    (cram_we),
        .cram_waddr (cram_waddr),
        .cram_wdata (cram_wdata),
        .pix_valid  (pix_valid),
        .pix_ready  (pix_ready),
        .pix_rgb    (pix_rgb),
        .done       (done),
        .bg_ctl     (bg_ctl),
        .bg_rgb     (bg_rgb)
    );

    function automatic logic [7:0] vmem(input logic [15:0] a);
        return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h5A;
    endfunction

    function automatic logic [23:0] exp_rgb(input logic [11:0] c);
        logic [23:0] r;
        r = '0;
        r[23:20] = c[3:0];
        r[15:12] = c[7:4];
        r[7:4]   = c[11:8];
        return r;
    endfunction

    function automatic logic [23:0] exp_pixel(input logic [15:0] name, input int k);
        logic [15:0] a;
        logic [7:0]  b;
        logic [3:0]  nib;
        a   = {name[10:0], 5'b0} + 16'(k / 2);
        b   = vmem(a);
        nib = (k % 2 == 0) ? b[7:4] : b[3:0];
        return exp_rgb(cram_model[{name[14:13], nib}]);
    endfunction

    // Pattern memory model: one cycle read latency.
    always_ff @(posedge clk) vram_rdata <= vmem(vram_addr);

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    task automatic cram_write(input logic [5:0] a, input logic [11:0] d);
        cram_we    = 1'b1;
        cram_waddr = a;
        cram_wdata = d;
        cram_model[a] = d;
        @(negedge clk);
        cram_we = 1'b0;
    endtask

    task automatic run_tile(input logic [15:0] name, input int stall_pct);
        int k = 0;
        int cyc = 0;
        int pix_bad = 0;
        int addr_bad = 0;
        int busy_bad = 0;
        int stall_bad = 0;
        bit held = 1'b0;
        logic [23:0] held_rgb = '0;
        logic [23:0] first_bad_act = '0;
        logic [23:0] first_bad_exp = '0;
        logic [15:0] ea;
        bit r;
        req_name  = name;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        req_name  = ~name;
        while (k < 64 && cyc < 2000) begin
            r = (($urandom % 100) >= stall_pct);
            pix_ready = r;
            if (held) begin
                if (!pix_valid || pix_rgb != held_rgb) stall_bad++;
                held = 1'b0;
            end
            if (req_ready) busy_bad++;
            if (vram_re) begin
                ea = {name[10:0], 5'b0} + 16'(k / 2);
                if (vram_addr != ea) addr_bad++;
            end
            if (pix_valid) begin
                if (r) begin
                    if (pix_rgb != exp_pixel(name, k)) begin
                        if (pix_bad == 0) begin
                            first_bad_act = pix_rgb;
                            first_bad_exp = exp_pixel(name, k);
                        end
                        pix_bad++;
                    end
                    k++;
                end else begin
                    held     = 1'b1;
                    held_rgb = pix_rgb;
                end
            end
            cyc++;
            @(negedge clk);
        end
        check(k == 64, "R6 pixel count", k, 64);
        check(pix_bad == 0, "R3 R4 R5 R10 pixel colours", first_bad_act, first_bad_exp);
        check(addr_bad == 0, "R2 read addresses", addr_bad, 0);
        check(stall_bad == 0, "R7 stall hold", stall_bad, 0);
        check(busy_bad == 0, "R6 ready low while busy", busy_bad, 0);
        check(done == 1'b1 && !pix_valid && req_ready, "R6 done after last pixel",
              {done, pix_valid, req_ready}, 3'b101);
        pix_ready = 1'b1;
        @(negedge clk);
        check(done == 1'b0 && !pix_valid, "R6 done single cycle", {done, pix_valid}, 2'b00);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h1DE5_0F17));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(req_ready && !pix_valid && !done, "R1 reset outputs",
              {req_ready, pix_valid, done}, 3'b100);

        // R9 load colour store
        for (int i = 0; i < 64; i++) cram_write(6'(i), 12'($urandom));

        // R8 background lookup, upper bits random
        for (int i = 0; i < 8; i++) begin
            logic [7:0] b;
            b = 8'($urandom);
            bg_ctl = b;
            #1;
            check(bg_rgb == exp_rgb(cram_model[b[5:0]]), "R8 background colour",
                  bg_rgb, exp_rgb(cram_model[b[5:0]]));
            @(negedge clk);
        end
        // R8 bits 7:6 have no effect
        bg_ctl = 8'h05;
        #1;
        begin
            logic [23:0] ref_bg;
            ref_bg = bg_rgb;
            bg_ctl = 8'hC5;
            #1;
            check(bg_rgb == ref_bg, "R8 bg_ctl upper bits ignored", bg_rgb, ref_bg);
        end
        @(negedge clk);

        // R9 write visible next cycle
        bg_ctl = 8'h2A;
        cram_write(6'h2A, 12'hABC);
        check(bg_rgb == 24'hC0B0A0, "R9 write visible", bg_rgb, 24'hC0B0A0);
        check(bg_rgb[19:16] == 4'h0 && bg_rgb[11:8] == 4'h0 && bg_rgb[3:0] == 4'h0,
              "R5 zero low nibbles", bg_rgb, 24'hC0B0A0);

        // Directed tiles
        run_tile(16'h0000, 0);
        run_tile(16'h7FFF, 0);     // R10 bits 12:11 set, top tile
        run_tile(16'hA123, 50);    // R10 bit 15 set, palette 1
        run_tile(16'h4400, 80);

        // Random tiles with random stalls
        for (int t = 0; t < 8; t++) begin
            run_tile(16'($urandom), int'($urandom % 70));
        end

        // R10 same tile/palette with ignored bits flipped gives same pixels
        run_tile(16'h1855, 30);
        run_tile(16'h9055, 30);

        finish_run();
    end

endmodule